// File: doc/BRIEF.md
# Cascadable Configuration Bitstream Streamer

This block is the read side of a one-time-programmable store that holds a configuration image for a programmable-logic device. The consumer, or a free-running oscillator, drives the configuration clock. The block presents the next unit of the image shortly after each rising edge, and the consumer captures it on the following rising edge. The block has two output widths that share one address counter. In byte-wide mode it presents a whole stored byte on each clock. In serial mode it presents one bit on each clock, starting with the most significant bit of each byte.

Several instances form a chain. The hand-off output of one instance feeds the enable input of the next, and every instance shares the clock and the data bus. Once an instance has delivered its last stored unit, it releases the bus and asserts its hand-off, so the next instance takes over on the next cycle with no gap. The reset input has a selectable active level. While reset is active, the counters return to zero and the storage is reloaded with the image, which is computed from a seed parameter.

Top module: `cfg_stream_rom`

## Requirements
- R1: The reset is active when `rst_in` equals `rst_hi_sel`. While it is active, `dout_oe` is 0, and the stream restarts at byte 0, bit 7 once reset is released, including when reset is applied in the middle of a stream.
- R2: In byte mode (`byte_mode`=1), while enabled and not exhausted, `dout[7:0]` shows stored byte k during the cycle after the k-th rising edge since the stream started. The address advances by one on each rising edge.
- R3: In serial mode (`byte_mode`=0), the bit is presented on `dout[0]` and `dout[7:1]` reads 0. Bits of each byte leave most significant first (bit 7 down to bit 0), and the address advances after the eighth bit.
- R4: While `ce_n` is 1, `dout_oe` is 0 and the address and bit counters hold. After re-enable, the stream resumes at the unit that would have come next.
- R5: After the last unit of the image has been presented and clocked, the block releases the bus (`dout_oe`=0). While `ce_n` is 0, it drives `ceo_n` to 0.
- R6: `ceo_n` is 1 whenever `ce_n` is 1. The exhausted state persists across disable and re-enable until the next reset.
- R7: Two instances chained through `ceo_n`→`ce_n` produce, on the shared bus, the first image followed directly by the second. Exactly one instance drives the bus in each cycle of the stream.
- R8: The stored byte at address a equals ((37·a + 11·IMG_SEED + ⌊a/4⌋) mod 256) XOR 0x5A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cfg | input | 1 | Configuration clock, from the consumer or a free-running oscillator |
| rst_in | input | 1 | Reset request; its active level is set by rst_hi_sel |
| rst_hi_sel | input | 1 | 1: reset is active high; 0: reset is active low |
| ce_n | input | 1 | Active-low enable, driven by the consumer or by the previous ceo_n in a chain |
| byte_mode | input | 1 | 1: one byte per clock; 0: one bit per clock on dout[0] |
| dout | output | 8 | Data to the shared bus; valid while dout_oe is 1 |
| dout_oe | output | 1 | Output enable; 0 models a high-impedance bus |
| ceo_n | output | 1 | Active-low hand-off to the next instance in the chain |

## Verification
The hardest case to reach is a pause in the middle of a serial byte that falls inside the first instance of a chain. Here the enable drops while the bit counter sits inside a byte, and the stream must resume on exactly the next bit. The bench reaches this case by streaming serially through both chained instances and raising `ce_n` for three cycles at a mid-byte bit position. It then checks the bit after the pause and the seamless hand-off at the image boundary. A second hard case is a reset asserted mid-stream under the active-low setting, which the bench applies after a few bytes in byte mode.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

  // Stored image content, computed from seed and byte address.
  function automatic logic [7:0] img_byte(input int unsigned seed, input int unsigned a);
    int unsigned v;
    v = a * 37 + seed * 11 + (a >> 2);
    return 8'(v) ^ 8'h5A;
  endfunction

  // Serial output: bit counter 0 selects the MSB.
  function automatic logic pick_bit(input logic [7:0] b, input logic [2:0] bitc);
    return b[3'd7 - bitc];
  endfunction

endpackage

// File: rtl/cfgs_addr_ctr.sv
module cfgs_addr_ctr #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_act,
  input  logic          ce_n,
  input  logic          byte_mode,
  output logic [AW-1:0] addr,
  output logic [2:0]    bitc,
  output logic          done
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic adv_en;
  logic at_last;
  logic byte_end;
  assign adv_en   = !ce_n && !done;
  assign at_last  = (addr == LAST);
  assign byte_end = byte_mode || (bitc == 3'd7);

  always_ff @(posedge clk) begin
    if (rst_act) begin
      addr <= '0;
      bitc <= '0;
      done <= 1'b0;
    end else if (adv_en) begin
      if (byte_mode) bitc <= '0;
      else           bitc <= bitc + 3'd1;
      if (byte_end) begin
        if (at_last) done <= 1'b1;
        else         addr <= addr + AW'(1);
      end
    end
  end

  p_reset_zero_r1: assert property (@(posedge clk)
    rst_act |=> (addr == '0 && bitc == '0 && !done));

  p_hold_disabled_r4: assert property (@(posedge clk) disable iff (rst_act)
    ce_n |=> ($stable(addr) && $stable(bitc) && $stable(done)));

  p_byte_step_r2: assert property (@(posedge clk) disable iff (rst_act)
    (!ce_n && !done && byte_mode && !at_last) |=> (addr == AW'($past(addr) + 1'b1)));

  p_serial_step_r3: assert property (@(posedge clk) disable iff (rst_act)
    (!ce_n && !done && !byte_mode && bitc != 3'd7)
      |=> (addr == $past(addr) && bitc == 3'($past(bitc) + 1'b1)));

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (rst_act)
    done |=> done);
endmodule

// File: rtl/cfgs_store.sv
module cfgs_store #(
  parameter int DEPTH    = 16,
  parameter int IMG_SEED = 0,
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_act,
  input  logic [AW-1:0] addr,
  output logic [7:0]    rd_byte
);
  import cfgs_pkg::*;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst_act) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= img_byte(IMG_SEED, i);
    end
  end

  assign rd_byte = mem[addr];
endmodule

// File: rtl/cfgs_out_sel.sv
module cfgs_out_sel (
  input  logic       clk,
  input  logic       rst_act,
  input  logic       ce_n,
  input  logic       done,
  input  logic       byte_mode,
  input  logic [7:0] rd_byte,
  input  logic [2:0] bitc,
  output logic [7:0] dout,
  output logic       dout_oe,
  output logic       ceo_n
);
  import cfgs_pkg::*;

  assign dout    = byte_mode ? rd_byte : {7'b0, pick_bit(rd_byte, bitc)};
  assign dout_oe = !ce_n && !done && !rst_act;
  assign ceo_n   = !(done && !ce_n);

  p_bus_free_done_r5: assert property (@(posedge clk) disable iff (rst_act)
    done |-> !dout_oe);

  p_ceo_follows_ce_r6: assert property (@(posedge clk) disable iff (rst_act)
    ce_n |-> ceo_n);

  p_serial_upper_zero_r3: assert property (@(posedge clk) disable iff (rst_act)
    !byte_mode |-> (dout[7:1] == 7'd0));
endmodule

// File: rtl/cfg_stream_rom.sv
module cfg_stream_rom #(
  parameter int DEPTH    = 16,
  parameter int IMG_SEED = 0,
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic       clk_cfg,
  input  logic       rst_in,
  input  logic       rst_hi_sel,
  input  logic       ce_n,
  input  logic       byte_mode,
  output logic [7:0] dout,
  output logic       dout_oe,
  output logic       ceo_n
);
  logic          rst_act;
  logic [AW-1:0] addr;
  logic [2:0]    bitc;
  logic          done;
  logic [7:0]    rd_byte;

  assign rst_act = (rst_in == rst_hi_sel);

  cfgs_addr_ctr #(.DEPTH(DEPTH)) ctr_i (
    .clk(clk_cfg), .rst_act(rst_act), .ce_n(ce_n), .byte_mode(byte_mode),
    .addr(addr), .bitc(bitc), .done(done)
  );

  cfgs_store #(.DEPTH(DEPTH), .IMG_SEED(IMG_SEED)) store_i (
    .clk(clk_cfg), .rst_act(rst_act), .addr(addr), .rd_byte(rd_byte)
  );

  cfgs_out_sel out_i (
    .clk(clk_cfg), .rst_act(rst_act), .ce_n(ce_n), .done(done),
    .byte_mode(byte_mode), .rd_byte(rd_byte), .bitc(bitc),
    .dout(dout), .dout_oe(dout_oe), .ceo_n(ceo_n)
  );

  p_reset_no_drive_r1: assert property (@(posedge clk_cfg)
    rst_act |-> !dout_oe);
endmodule

// File: tb/cfg_stream_rom_tb.sv
module cfg_stream_rom_tb_top;
  localparam int CLK_P = 10;
  localparam int DEP   = 8;
  localparam int SEED0 = 3;
  localparam int SEED1 = 29;

  logic clk = 1'b0;
  logic rst_in, rst_hi_sel, ce_n, byte_mode;
  logic [7:0] d0, d1;
  logic oe0, oe1, ceo0_n, ceo1_n;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  cfg_stream_rom #(.DEPTH(DEP), .IMG_SEED(SEED0)) dut_i (
    .clk_cfg(clk), .rst_in(rst_in), .rst_hi_sel(rst_hi_sel), .ce_n(ce_n),
    .byte_mode(byte_mode), .dout(d0), .dout_oe(oe0), .ceo_n(ceo0_n)
  );
  cfg_stream_rom #(.DEPTH(DEP), .IMG_SEED(SEED1)) dut_b (
    .clk_cfg(clk), .rst_in(rst_in), .rst_hi_sel(rst_hi_sel), .ce_n(ceo0_n),
    .byte_mode(byte_mode), .dout(d1), .dout_oe(oe1), .ceo_n(ceo1_n)
  );

  function automatic logic [7:0] exp_byte(int s, int a);
    int v;
    v = (a * 37 + s * 11 + a / 4) % 256;
    return 8'(v ^ 90);
  endfunction

  // Unit k of the concatenated image (byte index across both devices)
  function automatic logic [7:0] cat_byte(int k);
    return (k < DEP) ? exp_byte(SEED0, k) : exp_byte(SEED1, k - DEP);
  endfunction

  function automatic logic [7:0] bus_val();
    return oe0 ? d0 : (oe1 ? d1 : 8'hEE);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic ce);
    @(negedge clk);
    rst_in = r;
    ce_n   = ce;
    #1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    rst_hi_sel = 1'b1; rst_in = 1'b1; ce_n = 1'b0; byte_mode = 1'b1;
    // R1: active-high reset, bus undriven
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b0);
      chk(!oe0 && !oe1, "R1", {oe0, oe1}, 0);
    end
    // R2 R7 R8: byte mode through the chain
    for (int k = 0; k < 2 * DEP; k++) begin
      step(1'b0, 1'b0);
      chk((oe0 ^ oe1) == 1'b1, "R7", {oe0, oe1}, (k < DEP) ? 2 : 1);
      chk(bus_val() == cat_byte(k), (k < DEP) ? "R2" : "R8", bus_val(), cat_byte(k));
      if (k >= DEP) chk(ceo0_n == 1'b0, "R5", ceo0_n, 0);
    end
    // R5: both exhausted
    step(1'b0, 1'b0);
    chk(!oe0 && !oe1, "R5", {oe0, oe1}, 0);
    chk(ceo1_n == 1'b0, "R5", ceo1_n, 0);
    // R6: disable forces ceo_n high; exhausted state persists
    step(1'b0, 1'b1);
    chk(ceo0_n && ceo1_n, "R6", {ceo0_n, ceo1_n}, 3);
    chk(!oe0 && !oe1, "R4", {oe0, oe1}, 0);
    step(1'b0, 1'b0);
    chk(!oe0 && !oe1 && !ceo1_n, "R6", {oe0, oe1, ceo1_n}, 0);

    // R1: active-low reset, then serial mode
    rst_hi_sel = 1'b0; byte_mode = 1'b0;
    for (int i = 0; i < 2; i++) begin
      step(1'b0, 1'b0);
      chk(!oe0 && !oe1, "R1", {oe0, oe1}, 0);
    end
    for (int g = 0; g < 2 * DEP * 8; g++) begin
      logic exp_b;
      if (g == 19) begin
        for (int p = 0; p < 3; p++) begin
          step(1'b1, 1'b1);
          chk(!oe0 && !oe1 && ceo0_n, "R4", {oe0, oe1, ceo0_n}, 1);
        end
      end
      step(1'b1, 1'b0);
      exp_b = cat_byte(g / 8)[7 - (g % 8)];
      chk(bus_val() == {7'd0, exp_b}, (g == 19) ? "R4" : "R3", bus_val(), {7'd0, exp_b});
    end
    step(1'b1, 1'b0);
    chk(!oe0 && !oe1 && !ceo1_n, "R5", {oe0, oe1, ceo1_n}, 0);

    // R1: mid-stream reset restarts at byte 0 (active low)
    byte_mode = 1'b1;
    step(1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 1'b0);
      chk(bus_val() == cat_byte(k), "R2", bus_val(), cat_byte(k));
    end
    step(1'b0, 1'b0);
    chk(!oe0 && !oe1, "R1", {oe0, oe1}, 0);
    step(1'b1, 1'b0);
    chk(bus_val() == cat_byte(0), "R1", bus_val(), cat_byte(0));
    step(1'b1, 1'b0);
    chk(bus_val() == cat_byte(1), "R2", bus_val(), cat_byte(1));

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule